// File: doc/BRIEF.md
# Debounced Pushbutton Press Counter

This block takes one raw contact input from a mechanical switch or pushbutton, sampled by a fast system clock. It delivers a clean, bounce-free level, a one-cycle pulse for each real press, and an 8-bit count of presses. The raw pin first passes through a short register chain. No other logic sees the raw pin before that chain. A settle-window filter comes next. Its default length is 10 ms at 50 MHz, or 500,000 cycles. The filter absorbs bounce bursts of about 5 to 5.5 ms with up to 20 full swings, and it also absorbs single-cycle runts.

A registered rising-edge detector compares the filtered level with its value from the previous cycle and emits the press pulse. The counter advances only on that pulse. A button held for millions of cycles therefore adds exactly one. A polarity parameter folds active-low buttons so that "pressed" is always 1 internally. The window, the chain depth and the counter width are parameters.

Top module: `btn_press_counter`

## Requirements
- R1: The raw input passes through SYNC_STAGES flip-flops before any other logic. For a clean, stable change of the raw pin applied between clock edges, level_o takes the new value exactly SYNC_STAGES + SETTLE_CYCLES rising edges later.
- R2: With ACTIVE_LOW = 1, a raw value of 0 means pressed and 1 means released. level_o is 1 while the button is accepted as pressed.
- R3: level_o changes only after the registered input has differed from it for SETTLE_CYCLES consecutive cycles. Any return to the current level restarts the window. The default window is SETTLE_US = 10000 at CLK_HZ = 50,000,000, which is 500,000 cycles.
- R4: Single-cycle runt glitches, and bounce bursts of up to 20 transitions whose pulses are all shorter than the window, cause no extra press and no level change.
- R5: press_o is high for exactly one cycle per accepted press. It rises one edge after level_o rises, and a release produces no pulse.
- R6: count_o increases by exactly one for each press pulse, on the edge after the pulse. It never changes otherwise, however long the button is held.
- R7: count_o is CNT_W = 8 bits wide and wraps from 255 to 0.
- R8: While rst_ni is low (asynchronous, active low), level_o = 0, press_o = 0 and count_o = 0. A button already held through reset is counted once, when it is first accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_raw_i | input | 1 | Raw contact input, polarity set by ACTIVE_LOW |
| level_o | output | 1 | Debounced level, 1 = pressed |
| press_o | output | 1 | One-cycle registered pulse per press |
| count_o | output | CNT_W | Press count, wraps |

## Verification
The assertions assume the input obeys the filter's contract. Every bounce pulse is shorter than the settle window, and a settled press or release is held longer than the window plus the register latency. Without that, a long bounce would be a real press and the one-pulse-per-episode expectation would not hold. The bench generates bursts from $urandom with a fixed seed. Each burst has 1 to 20 toggles, with pulse widths capped three cycles below the window. After each burst it holds the final value well past the window. Directed cases add exact latency, runts, a long hold, a press held through reset and counter wrap.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int unsigned DEF_CLK_HZ    = 50_000_000;
  localparam int unsigned DEF_SETTLE_US = 10_000;

  function automatic int unsigned settle_cycles(input int unsigned clk_hz,
                                                input int unsigned us);
    return us * (clk_hz / 1_000_000);
  endfunction
endpackage

// File: rtl/bpc_input_reg.sv
module bpc_input_reg #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          ACTIVE_LOW  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic pressed_o
);
  localparam logic POL = ACTIVE_LOW;

  logic [SYNC_STAGES-1:0] sr_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= raw_i ^ POL;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[SYNC_STAGES-2:0], raw_i ^ POL};
      end
    end
  endgenerate

  assign pressed_o = sr_q[SYNC_STAGES-1];

  initial assert (SYNC_STAGES >= 1);
endmodule

// File: rtl/bpc_settle_filter.sv
module bpc_settle_filter #(
  parameter int unsigned SETTLE_CYCLES = 500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  output logic level_o
);
  localparam int unsigned TW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(SETTLE_CYCLES - 1);

  logic          level_q;
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      tmr_q   <= '0;
    end else if (sample_i == level_q) begin
      tmr_q   <= '0;
    end else if (tmr_q == LAST) begin
      level_q <= sample_i;
      tmr_q   <= '0;
    end else begin
      tmr_q   <= tmr_q + TW'(1);
    end
  end

  assign level_o = level_q;

  initial assert (SETTLE_CYCLES >= 2);

  // R3: level moves only at the end of a full window
  assert_level_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_q) |-> $past(tmr_q) == LAST);

  // R3: agreeing sample keeps the level
  assert_level_match_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i == level_q) |=> $stable(level_q));

  assert_timer_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q <= LAST);
endmodule

// File: rtl/bpc_rise_pulse.sv
module bpc_rise_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  logic prev_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= level_i;
      pulse_q <= level_i & ~prev_q;
    end
  end

  assign pulse_o = pulse_q;

  assert_press_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);

  // R5: a pulse only follows a level that is now high
  assert_press_needs_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> level_i);
endmodule

// File: rtl/bpc_event_count.sv
module bpc_event_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (event_i) count_q <= count_q + CNT_W'(1);
  end

  assign count_o = count_q;

  assert_count_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !event_i |=> $stable(count_q));

  assert_count_moves_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> !$stable(count_q));
endmodule

// File: rtl/btn_press_counter.sv
module btn_press_counter #(
  parameter int unsigned CLK_HZ      = bpc_pkg::DEF_CLK_HZ,
  parameter int unsigned SETTLE_US   = bpc_pkg::DEF_SETTLE_US,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          ACTIVE_LOW  = 1'b1,
  parameter int unsigned CNT_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             btn_raw_i,
  output logic             level_o,
  output logic             press_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned SETTLE_CYCLES = bpc_pkg::settle_cycles(CLK_HZ, SETTLE_US);

  logic pressed_s, level_s, press_s;

  bpc_input_reg #(.SYNC_STAGES(SYNC_STAGES), .ACTIVE_LOW(ACTIVE_LOW)) u_in (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(btn_raw_i), .pressed_o(pressed_s));

  bpc_settle_filter #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(pressed_s), .level_o(level_s));

  bpc_rise_pulse u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level_s), .pulse_o(press_s));

  bpc_event_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .event_i(press_s), .count_o(count_o));

  assign level_o = level_s;
  assign press_o = press_s;
endmodule

// File: tb/btn_press_counter_bench.sv
module btn_press_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 20;           // 1 MHz * 20 us
  localparam int STAGES = 2;
  localparam int LAT    = STAGES + SETTLE;
  localparam logic PRESS = 1'b0;        // R2: active low
  localparam logic REL   = 1'b1;

  logic clk = 1'b0, rst_ni = 1'b0, raw = REL;
  logic level_o, press_o;
  logic [7:0] count_o;

  int checks = 0, fails = 0, pulses = 0;
  logic prev_press = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btn_press_counter #(.CLK_HZ(1_000_000), .SETTLE_US(SETTLE), .SYNC_STAGES(STAGES),
                      .ACTIVE_LOW(1'b1), .CNT_W(8)) u_btn_press_counter (
    .clk_i(clk), .rst_ni(rst_ni), .btn_raw_i(raw),
    .level_o(level_o), .press_o(press_o), .count_o(count_o));

  function automatic logic [7:0] exp_count(input logic [7:0] base, input int n);
    return 8'((int'(base) + n) % 256);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // press pulse monitor (R5)
  always @(negedge clk) begin
    if (rst_ni) begin
      if (press_o) pulses++;
      if (press_o && prev_press) begin
        checks++; fails++;
        $display("FAIL R5 act=2-cycle pulse exp=1-cycle");
      end
    end
    prev_press = press_o;
  end

  // bounce burst of 1..20 toggles, each pulse shorter than the window, ending on tgt
  task automatic bounce(input logic tgt);
    int k = 1 + int'($urandom % 20);
    for (int i = 0; i < k; i++) begin
      raw = ((k - 1 - i) % 2 == 0) ? tgt : ~tgt;
      tick(1 + int'($urandom % (SETTLE - 3)));
    end
    raw = tgt;
  endtask

  task automatic episode(input int hold);
    bounce(PRESS);
    tick(hold);
    bounce(REL);
    tick(LAT + 6);
  endtask

  initial begin
    logic [7:0] base;
    int p0;
    void'($urandom(32'h1badcafe));

    // R8: reset state
    tick(3);
    chk("R8 level", level_o, 0);
    chk("R8 press", press_o, 0);
    chk("R8 count", count_o, 0);
    rst_ni = 1'b1;
    tick(LAT + 6);
    chk("R8 idle count", count_o, 0);

    // R1/R2/R5/R6: exact latency of a clean press
    raw = PRESS;
    tick(LAT - 1);
    chk("R1 level before", level_o, 0);
    tick(1);
    chk("R1 level after", level_o, 1);
    chk("R5 press not yet", press_o, 0);
    tick(1);
    chk("R5 press high", press_o, 1);
    chk("R6 count before", count_o, 0);
    tick(1);
    chk("R5 press low", press_o, 0);
    chk("R6 count after", count_o, 1);

    // R6: long hold counts once
    tick(2000);
    chk("R6 long hold", count_o, 1);
    raw = REL;
    p0 = pulses;
    tick(LAT + 4);
    chk("R2 release level", level_o, 0);
    chk("R5 no pulse on release", pulses - p0, 0);

    // R3/R4: single-cycle runts while idle and while held
    p0 = pulses;
    for (int i = 0; i < 10; i++) begin
      raw = PRESS; tick(1); raw = REL; tick(3 + int'($urandom % 5));
    end
    chk("R4 runts idle level", level_o, 0);
    chk("R4 runts idle pulses", pulses - p0, 0);

    // R3: window restart, pulse of SETTLE-1 registered cycles never accepted
    raw = PRESS; tick(SETTLE - 1); raw = REL; tick(2);
    raw = PRESS; tick(SETTLE - 1); raw = REL;
    tick(LAT + 4);
    chk("R3 restart level", level_o, 0);
    chk("R3 restart pulses", pulses - p0, 0);

    // R4/R6: random bounce episodes
    base = count_o;
    p0 = pulses;
    for (int e = 0; e < 40; e++) episode(LAT + 4 + int'($urandom % 50));
    chk("R4 burst pulses", pulses - p0, 40);
    chk("R6 burst count", count_o, exp_count(base, 40));

    // R7: wrap
    base = count_o;
    for (int e = 0; e < 256 - int'(base) + 3; e++) episode(LAT + 4);
    chk("R7 wrap count", count_o, 3);

    // R8: button held through reset counts once
    raw = PRESS;
    rst_ni = 1'b0;
    tick(3);
    chk("R8 reset count", count_o, 0);
    chk("R8 reset level", level_o, 0);
    rst_ni = 1'b1;
    tick(LAT + 6);
    chk("R8 held at reset", count_o, 1);
    tick(500);
    chk("R8 held stays", count_o, 1);
    raw = REL;
    tick(LAT + 6);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule